// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block is a small multi-cycle controller that owns a stack pointer and a program counter and runs every stack-related operation of an 8-bit processor core over a byte-wide memory port. Each cycle it makes at most one memory access. It can push or pop a 16-bit register pair, or the accumulator together with its flag byte. It handles calls and returns, both unconditional and conditional, and restarts to fixed vectors. It can swap the word on top of the stack with a register pair, and it can load the stack pointer or the program counter from a register pair.

The core fetches and decodes instructions and evaluates condition codes elsewhere. It then hands this block a command code, a 16-bit operand and a condition bit. The sequencer takes the command only while it is idle. It steps through the accesses it needs and raises `done` for one cycle once the last access is finished. Memory is read combinationally: the byte at `mem_addr` must appear on `mem_rdata` in the same cycle. Words are stored with the high byte at the higher address.

Top module: `stk_seq`

## Requirements
- R1: Command 1 (push pair) writes operand[15:8] to SP-1 in the first access cycle and operand[7:0] to SP-2 in the next cycle. SP then ends at SP-2.
- R2: Command 3 (push status) uses the same layout as R1. The accumulator (operand[15:8]) goes to the higher address and the flag byte (operand[7:0]) to the lower address.
- R3: Commands 2 (pop pair) and 4 (pop status) read the low byte at SP and the high byte at SP+1. They present {high, low} on `pair_rd` and leave SP at SP+2.
- R4: Command 5 (call) stores the current PC as R1 stores a word, lowers SP by 2 and loads PC with the operand.
- R5: Command 7 (return) loads PC with {mem[SP+1], mem[SP]} and raises SP by 2. `pair_rd` is not changed.
- R6: Command 9 (restart) takes its index from operand[2:0]. It saves PC as a call does and sets PC to index×8.
- R7: Command 10 (exchange) reads SP, then SP+1, then writes operand[7:0] to SP and operand[15:8] to SP+1. The old word appears on `pair_rd` and SP is unchanged.
- R8: Commands 6 (conditional call) and 8 (conditional return) act as commands 5 and 7 only when `cond_true` is 1 in the accept cycle. When it is 0 they make no memory access, leave SP and PC unchanged, and still pulse `done` one cycle after being accepted.
- R9: Command 11 loads SP from the operand and command 12 loads PC from the operand. Neither makes a memory access, and `done` follows one cycle after acceptance.
- R10: SP arithmetic wraps modulo 65536. A push from SP=0001h writes addresses 0000h and FFFFh.
- R11: `done` is high for exactly one cycle, in the cycle after the final memory access (three cycles after acceptance for two-access commands, five for the exchange). Commands presented while `busy` is high are ignored. Codes 0, 13, 14 and 15 are ignored and produce no `done`.
- R12: After reset, SP is 0000h, PC is 0000h, and `done`, `busy` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 4 | Command code |
| operand | input | 16 | Pair value, target address or restart index |
| cond_true | input | 1 | Condition outcome for conditional commands |
| mem_rdata | input | 8 | Read byte for the current address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write byte |
| mem_we | output | 1 | Write strobe |
| pair_rd | output | 16 | Word captured by a pop or an exchange |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A command is in progress |
| sp_q | output | 16 | Stack pointer |
| pc_q | output | 16 | Program counter |

## Verification
The bench runs a chain of dependent commands, so a byte-order error in any of them shows up in a later return or pop. For example, swapped push lanes would bring back a byte-reversed return address. Conditional commands are issued with the condition both false and true. A design that decoded the condition wrongly would write to the stack or move SP when it should not. The exchange is checked for both the old word it returns and the new bytes it leaves behind. A design that drifted SP or wrote before reading would fail those checks. Stack-pointer wrap across 0000h, a command injected while busy, and unused codes are also tested. These catch a truncated pointer, a controller that re-accepts input mid-sequence, and a decoder that treats unused codes as live.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [3:0] {
      OP_NONE   = 4'd0,
      OP_PUSH   = 4'd1,
      OP_POP    = 4'd2,
      OP_PUSHST = 4'd3,
      OP_POPST  = 4'd4,
      OP_CALL   = 4'd5,
      OP_CCALL  = 4'd6,
      OP_RET    = 4'd7,
      OP_CRET   = 4'd8,
      OP_RST    = 4'd9,
      OP_XTOP   = 4'd10,
      OP_LDSP   = 4'd11,
      OP_LDPC   = 4'd12
   } stk_op_e;

   // access pattern of an accepted command
   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_WR2  = 2'd1,
      K_RD2  = 2'd2,
      K_XCH  = 2'd3
   } stk_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } stk_state_e;
endpackage

// File: rtl/stk_seq_ctl.sv
module stk_seq_ctl #(
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [SW:0]   nsteps,
   output logic          busy,
   output logic          in_run,
   output logic [SW-1:0] step,
   output logic          last,
   output logic          done
);
   import stk_pkg::*;

   stk_state_e st_q;
   logic [SW:0] n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         step <= '0;
         n_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               n_q  <= nsteps;
               step <= '0;
               st_q <= (nsteps == '0) ? ST_FIN : ST_RUN;
            end
            ST_RUN: begin
               if (last) st_q <= ST_FIN;
               else      step <= step + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != ST_IDLE);
   assign in_run = (st_q == ST_RUN);
   assign done   = (st_q == ST_FIN);
   assign last   = in_run && ({1'b0, step} == (n_q - 1'b1));
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int             AW   = 16,
   parameter logic [AW-1:0]  INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   input  logic          dec,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_p1,
   output logic [AW-1:0] sp_m1
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= INIT;
      else if (load) sp <= load_val;
      else if (inc)  sp <= sp_p1;
      else if (dec)  sp <= sp_m1;
   end

   // modulo 2**AW by plain width truncation
   assign sp_p1 = sp + 1'b1;
   assign sp_m1 = sp - 1'b1;
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
   parameter int            AW        = 16,
   parameter int            DW        = 8,
   parameter int            IDXW      = 3,
   parameter int            VEC_SHIFT = 3,
   parameter logic [AW-1:0] SP_INIT   = '0,
   parameter logic [AW-1:0] PC_INIT   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [3:0]    cmd,
   input  logic [AW-1:0] operand,
   input  logic          cond_true,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic [AW-1:0] pair_rd,
   output logic          done,
   output logic          busy,
   output logic [AW-1:0] sp_q,
   output logic [AW-1:0] pc_q
);
   import stk_pkg::*;

   localparam int PW = 2 * DW;
   localparam int SW = 2;   // step counter width, longest command = 4 accesses

   generate
      if (AW != PW) begin : g_bad_width
         $error("stk_seq: address width must equal two data bytes");
      end
      if (IDXW + VEC_SHIFT > AW) begin : g_bad_vec
         $error("stk_seq: restart vector does not fit the address");
      end
   endgenerate

   // ---------------- decode at acceptance ----------------
   logic          accept, start, known;
   stk_kind_e     kind_n;
   logic [SW:0]   nsteps_n;
   logic          save_pc_n, ret_n, rst_n_cmd;
   logic [AW-1:0] vec_addr;

   assign accept   = cmd_valid && !busy;
   assign vec_addr = {{(AW-IDXW){1'b0}}, operand[IDXW-1:0]} << VEC_SHIFT;

   always_comb begin
      known     = 1'b1;
      kind_n    = K_NONE;
      nsteps_n  = '0;
      save_pc_n = 1'b0;
      ret_n     = 1'b0;
      rst_n_cmd = 1'b0;
      case (cmd)
         OP_PUSH, OP_PUSHST: begin kind_n = K_WR2; nsteps_n = 3'd2; end
         OP_POP, OP_POPST:   begin kind_n = K_RD2; nsteps_n = 3'd2; end
         OP_CALL:            begin kind_n = K_WR2; nsteps_n = 3'd2; save_pc_n = 1'b1; end
         OP_CCALL: if (cond_true) begin
            kind_n = K_WR2; nsteps_n = 3'd2; save_pc_n = 1'b1;
         end
         OP_RET:             begin kind_n = K_RD2; nsteps_n = 3'd2; ret_n = 1'b1; end
         OP_CRET: if (cond_true) begin
            kind_n = K_RD2; nsteps_n = 3'd2; ret_n = 1'b1;
         end
         OP_RST: begin
            kind_n = K_WR2; nsteps_n = 3'd2; save_pc_n = 1'b1; rst_n_cmd = 1'b1;
         end
         OP_XTOP:            begin kind_n = K_XCH; nsteps_n = 3'd4; end
         OP_LDSP, OP_LDPC:   ;
         default:            known = 1'b0;
      endcase
   end

   assign start = accept && known;

   // ---------------- step controller ----------------
   logic          in_run, last;
   logic [SW-1:0] step;

   stk_seq_ctl #(.SW(SW)) i_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .nsteps (nsteps_n),
      .busy   (busy),
      .in_run (in_run),
      .step   (step),
      .last   (last),
      .done   (done)
   );

   // ---------------- latched command state ----------------
   stk_kind_e     kind_q;
   logic [PW-1:0] wval_q;
   logic [AW-1:0] tgt_q;
   logic          jump_q, ret_q;
   logic [DW-1:0] lo_q;
   logic [AW-1:0] pc_r, pair_r;

   // ---------------- stack pointer ----------------
   logic          sp_load, sp_inc, sp_dec;
   logic [AW-1:0] sp_p1, sp_m1;

   assign sp_load = start && (cmd == OP_LDSP);
   assign sp_inc  = in_run && (kind_q == K_RD2);
   assign sp_dec  = in_run && (kind_q == K_WR2);

   stk_ptr #(.AW(AW), .INIT(SP_INIT)) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sp_load),
      .load_val (operand),
      .inc      (sp_inc),
      .dec      (sp_dec),
      .sp       (sp_q),
      .sp_p1    (sp_p1),
      .sp_m1    (sp_m1)
   );

   // ---------------- memory port ----------------
   always_comb begin
      mem_addr  = sp_q;
      mem_wdata = '0;
      mem_we    = 1'b0;
      if (in_run) begin
         case (kind_q)
            K_WR2: begin
               // high byte first at the higher address
               mem_addr  = sp_m1;
               mem_we    = 1'b1;
               mem_wdata = step[0] ? wval_q[DW-1:0] : wval_q[PW-1:DW];
            end
            K_RD2: mem_addr = sp_q;
            K_XCH: begin
               mem_addr  = step[0] ? sp_p1 : sp_q;
               mem_we    = step[1];
               mem_wdata = step[0] ? wval_q[PW-1:DW] : wval_q[DW-1:0];
            end
            default: ;
         endcase
      end
   end

   // ---------------- datapath registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_NONE;
         wval_q <= '0;
         tgt_q  <= '0;
         jump_q <= 1'b0;
         ret_q  <= 1'b0;
         lo_q   <= '0;
         pc_r   <= PC_INIT;
         pair_r <= '0;
      end else begin
         if (start) begin
            kind_q <= kind_n;
            wval_q <= save_pc_n ? pc_r : operand;
            tgt_q  <= rst_n_cmd ? vec_addr : operand;
            jump_q <= save_pc_n;
            ret_q  <= ret_n;
            if (cmd == OP_LDPC) pc_r <= operand;
         end
         if (in_run) begin
            if (step == '0 && kind_q != K_WR2) lo_q <= mem_rdata;
            if (kind_q == K_XCH && step == 2'd1) pair_r <= {mem_rdata, lo_q};
            if (last) begin
               if (kind_q == K_WR2 && jump_q) pc_r <= tgt_q;
               if (kind_q == K_RD2) begin
                  if (ret_q) pc_r   <= {mem_rdata, lo_q};
                  else       pair_r <= {mem_rdata, lo_q};
               end
            end
         end
      end
   end

   assign pc_q    = pc_r;
   assign pair_rd = pair_r;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          busy,
   input logic          done,
   input logic          mem_we,
   input logic [AW-1:0] sp_q,
   input logic [AW-1:0] pc_q
);
   logic [AW-1:0] sp_prev;
   logic [AW-1:0] sp_dlt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_prev <= '0;
      else        sp_prev <= sp_q;
   end
   assign sp_dlt = sp_q - sp_prev;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R11
   we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (busy && !done));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> ($stable(sp_q) && $stable(pc_q)));

   // R10
   sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (sp_dlt == '0 || sp_dlt == {{(AW-1){1'b0}}, 1'b1} || sp_dlt == '1));
endmodule

bind stk_seq stk_seq_chk #(.AW(AW)) i_stk_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .done      (done),
   .mem_we    (mem_we),
   .sp_q      (sp_q),
   .pc_q      (pc_q)
);

// File: tb/test_stk_seq.sv
`timescale 1ns/1ps
module test_stk_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd = '0;
   logic [15:0] operand = '0;
   logic        cond_true = 1'b0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [15:0] pair_rd, sp_q, pc_q;
   logic        done, busy;

   always #2 clk = ~clk;   // 250 MHz

   stk_seq i_stk_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .operand(operand), .cond_true(cond_true), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .pair_rd(pair_rd), .done(done), .busy(busy), .sp_q(sp_q), .pc_q(pc_q)
   );

   // 4 KiB memory model, addressed by the low 12 bits
   logic [7:0] mem [0:4095];
   int wr_cnt = 0;
   assign mem_rdata = mem[mem_addr[11:0]];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
      end else if (mem_we) begin
         mem[mem_addr[11:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [3:0]  cmd;
      logic [15:0] op;
      logic        cond;
      logic [15:0] sp;
      logic [15:0] pc;
      logic [15:0] pair;
      logic [3:0]  lat;
      logic [3:0]  wr;
      logic [15:0] maddr;
      logic [7:0]  mbyte;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VEC [14] = '{
      '{4'd11, 16'h2000, 1'b0, 16'h2000, 16'h0000, 16'h0000, 4'd1, 4'd0, 16'h1FFF, 8'h00, 8'd9}, // R9
      '{4'd12, 16'h1234, 1'b0, 16'h2000, 16'h1234, 16'h0000, 4'd1, 4'd0, 16'h1FFE, 8'h00, 8'd9}, // R9
      '{4'd1,  16'hABCD, 1'b0, 16'h1FFE, 16'h1234, 16'h0000, 4'd3, 4'd2, 16'h1FFF, 8'hAB, 8'd1}, // R1
      '{4'd3,  16'h5A81, 1'b0, 16'h1FFC, 16'h1234, 16'h0000, 4'd3, 4'd2, 16'h1FFC, 8'h81, 8'd2}, // R2
      '{4'd2,  16'h0000, 1'b0, 16'h1FFE, 16'h1234, 16'h5A81, 4'd3, 4'd0, 16'h1FFD, 8'h5A, 8'd3}, // R3
      '{4'd5,  16'h4000, 1'b0, 16'h1FFC, 16'h4000, 16'h5A81, 4'd3, 4'd2, 16'h1FFD, 8'h12, 8'd4}, // R4
      '{4'd6,  16'h5000, 1'b0, 16'h1FFC, 16'h4000, 16'h5A81, 4'd1, 4'd0, 16'h1FFC, 8'h34, 8'd8}, // R8
      '{4'd9,  16'h0005, 1'b0, 16'h1FFA, 16'h0028, 16'h5A81, 4'd3, 4'd2, 16'h1FFB, 8'h40, 8'd6}, // R6
      '{4'd7,  16'h0000, 1'b0, 16'h1FFC, 16'h4000, 16'h5A81, 4'd3, 4'd0, 16'h1FFA, 8'h00, 8'd5}, // R5
      '{4'd8,  16'h0000, 1'b0, 16'h1FFC, 16'h4000, 16'h5A81, 4'd1, 4'd0, 16'h1FFB, 8'h40, 8'd8}, // R8
      '{4'd10, 16'h9988, 1'b0, 16'h1FFC, 16'h4000, 16'h1234, 4'd5, 4'd2, 16'h1FFC, 8'h88, 8'd7}, // R7
      '{4'd8,  16'h0000, 1'b1, 16'h1FFE, 16'h9988, 16'h1234, 4'd3, 4'd0, 16'h1FFD, 8'h99, 8'd8}, // R8
      '{4'd4,  16'h0000, 1'b0, 16'h2000, 16'h9988, 16'hABCD, 4'd3, 4'd0, 16'h1FFE, 8'hCD, 8'd3}, // R3
      '{4'd6,  16'h7000, 1'b1, 16'h1FFE, 16'h7000, 16'hABCD, 4'd3, 4'd2, 16'h1FFE, 8'h88, 8'd8}  // R8
   };

   // issue one command, wait for done; lat counts negedges from issue to done
   task automatic run_cmd(input logic [3:0] c, input logic [15:0] o,
                          input logic cd, output int lat);
      @(negedge clk);
      cmd_valid = 1'b1; cmd = c; operand = o; cond_true = cd; wr_cnt = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int lat;
      string rq;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(sp_q == 16'h0000, "R12", "sp", sp_q, 16'h0000);
      chk(pc_q == 16'h0000, "R12", "pc", pc_q, 16'h0000);
      chk(!done && !busy && !mem_we, "R12", "done/busy/we", {done, busy, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VEC[k]) begin
         run_cmd(VEC[k].cmd, VEC[k].op, VEC[k].cond, lat);
         rq = $sformatf("R%0d row%0d", VEC[k].req, k);
         chk(lat == int'(VEC[k].lat), rq, "done latency", lat, VEC[k].lat);
         chk(sp_q == VEC[k].sp, rq, "sp", sp_q, VEC[k].sp);
         chk(pc_q == VEC[k].pc, rq, "pc", pc_q, VEC[k].pc);
         chk(pair_rd == VEC[k].pair, rq, "pair", pair_rd, VEC[k].pair);
         chk(wr_cnt == int'(VEC[k].wr), rq, "writes", wr_cnt, VEC[k].wr);
         chk(mem[VEC[k].maddr[11:0]] == VEC[k].mbyte, rq, "mem byte",
             mem[VEC[k].maddr[11:0]], VEC[k].mbyte);
         @(negedge clk);
         chk(!done, rq, "done width", done, 0);
      end

      // R10 wrap through zero
      run_cmd(4'd11, 16'h0001, 1'b0, lat);
      run_cmd(4'd1, 16'h1122, 1'b0, lat);
      chk(sp_q == 16'hFFFF, "R10", "sp after push", sp_q, 16'hFFFF);
      chk(mem[12'h000] == 8'h11, "R10", "byte at 0000", mem[12'h000], 8'h11);
      chk(mem[12'hFFF] == 8'h22, "R10", "byte at FFFF", mem[12'hFFF], 8'h22);
      run_cmd(4'd2, 16'h0000, 1'b0, lat);
      chk(pair_rd == 16'h1122, "R10", "pair after pop", pair_rd, 16'h1122);
      chk(sp_q == 16'h0001, "R10", "sp after pop", sp_q, 16'h0001);

      // R11 command while busy is ignored
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 4'd1; operand = 16'h7777; wr_cnt = 0;
      @(negedge clk);
      chk(busy, "R11", "busy after accept", busy, 1);
      cmd = 4'd11; operand = 16'h3000;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(done, "R11", "done timing", done, 1);
      chk(sp_q == 16'hFFFF, "R11", "sp ignores busy load", sp_q, 16'hFFFF);
      chk(wr_cnt == 2, "R11", "writes", wr_cnt, 2);

      // R11 unused codes
      run_cmd(4'd0, 16'h4444, 1'b1, lat);
      chk(lat == 12 && !done, "R11", "code 0 no done", lat, 12);
      run_cmd(4'd13, 16'h4444, 1'b1, lat);
      chk(lat == 12 && !done, "R11", "code 13 no done", lat, 12);
      chk(sp_q == 16'hFFFF && pc_q == 16'h7000, "R11", "state after unused",
          {sp_q, pc_q}, {16'hFFFF, 16'h7000});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule